// File: doc/BRIEF.md
# Board Control Register Bank

A memory-mapped slave that collects the small pieces of board control a processor expects to find at fixed offsets. It decodes a simple 32-bit read/write bus and keeps only the low 20 address bits, so the bank repeats across the rest of the address space. It holds an eight-LED bar byte, an eight-character ASCII display, a break/reset byte and a general-purpose output byte, and it exposes each of them as an output port for board logic to drive. It also exposes a set of constant identification registers.

Two writes have effects beyond plain storage. A single 32-bit write to the hex-word register fills the whole display with the value's uppercase hexadecimal digits. A write of a key value to the soft-reset register raises a one-cycle system reset request. A group of bit-banged I2C registers forwards clock and data levels to a separate serial-memory slave and returns that slave's data level on read. The general-purpose input register reads back the I2C output word while the I2C select bit is set.

Top module: `brdctl_regs`

## Requirements
- R1: After reset the LED byte is 0x00, break/reset is 0x0A, GP output is 0x00, I2C output enable is 0, I2C output word is 0x3 (so scl_o and sda_o are both 1), I2C select is 1, sys_rst_req is 0, and every display character is 0x20.
- R2: Only bus_addr[19:0] is decoded, so an access with any upper address bits reaches the same register as its low 20 bits.
- R3: A read at 0x200 (switches) or at 0x210 (jumpers) returns 0, and writes there change nothing. A read at 0x208 (status) returns 0x12 when BIG_ENDIAN=1 and 0x10 when BIG_ENDIAN=0.
- R4: The LED bar (0x408), break/reset (0x508) and GP output (0xA00) keep bits [7:0] of a write. I2C output enable (0xB08) keeps bits [1:0]. I2C select (0xB18) keeps bit 0. Each reads back what it kept.
- R5: A write to 0x410 sets display slot k, which is disp_chars[8k+7:8k], to the uppercase ASCII hex digit of data nibble [31-4k:28-4k]. Slot 0 therefore shows the most significant nibble. Digits 0 to 9 map to 0x30 to 0x39, and A to F map to 0x41 to 0x46.
- R6: A write to offset 0x418 + 8k, for k from 0 to 7, stores data[7:0] in slot k and leaves the other slots unchanged.
- R7: A write of exactly 0x00000042 to 0x500 sets sys_rst_req for the single cycle that follows the write edge. Any other data value leaves sys_rst_req at 0.
- R8: A read at 0xA08 returns the full I2C output word when I2C select is 1, and returns 0 when it is 0.
- R9: A read at 0xB00 returns 0x2 with bit 0 replaced by sda_i.
- R10: A write to 0xB10 stores the full 32-bit word, which reads back at 0xB10. From the next cycle onward, scl_o equals data bit 1 and sda_o equals data bit 0.
- R11: Reads at unmapped offsets, including misaligned offsets between display slots, return 0, and writes there change no output. bus_rdata is 0 whenever bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; low 20 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while bus_rd is high |
| sda_i | input | 1 | Data level returned by the serial-memory slave |
| scl_o | output | 1 | Clock level forwarded to the serial-memory slave |
| sda_o | output | 1 | Data level forwarded to the serial-memory slave |
| led_bar | output | 8 | LED bar byte |
| brk_byte | output | 8 | Break/reset byte |
| gp_out | output | 8 | General-purpose output byte |
| disp_chars | output | 64 | Display characters, slot k in bits [8k+7:8k] |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds two copies of the bank on the same bus: one with BIG_ENDIAN=1 and one with BIG_ENDIAN=0. Every status read therefore checks both variants of the generate branch in the same cycle. Both copies use the default 32-bit address, so the bench can drive upper address bits and show that they alias onto the 20-bit offset. The scenarios cover hex words whose digits fall on both sides of the 9/A boundary, a write to the last display slot and to a misaligned slot offset, and soft-reset data values that differ from the key in the low byte or only in the upper bits.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;

   localparam int unsigned OFF_W = 20;

   typedef logic [OFF_W-1:0] off_t;

   localparam off_t OFS_SWITCH  = 20'h00200;
   localparam off_t OFS_STATUS  = 20'h00208;
   localparam off_t OFS_JUMPER  = 20'h00210;
   localparam off_t OFS_LEDS    = 20'h00408;
   localparam off_t OFS_HEXWORD = 20'h00410;
   localparam off_t OFS_SLOT0   = 20'h00418;
   localparam off_t OFS_SWRST   = 20'h00500;
   localparam off_t OFS_BRK     = 20'h00508;
   localparam off_t OFS_GPOUT   = 20'h00A00;
   localparam off_t OFS_GPIN    = 20'h00A08;
   localparam off_t OFS_I2CIN   = 20'h00B00;
   localparam off_t OFS_I2COE   = 20'h00B08;
   localparam off_t OFS_I2COUT  = 20'h00B10;
   localparam off_t OFS_I2CSEL  = 20'h00B18;

   localparam logic [31:0] SWRST_KEY = 32'h0000_0042;
   localparam logic [7:0]  BRK_RST   = 8'h0A;
   localparam logic [7:0]  BLANK_CH  = 8'h20;

   // Uppercase ASCII digit for one nibble.
   function automatic logic [7:0] nib2ascii(input logic [3:0] n);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      else           return 8'h37 + {4'h0, n};
   endfunction

endpackage

// File: rtl/brdctl_charbank.sv
module brdctl_charbank
   import brdctl_pkg::*;
#(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned IDX_W = $clog2(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   input  logic [N_CH*4-1:0] word,
   input  logic              slot_we,
   input  logic [IDX_W-1:0]  slot_idx,
   input  logic [7:0]        slot_byte,
   output logic [N_CH*8-1:0] chars
);

   initial begin
      assert (N_CH >= 2) else $error("brdctl_charbank: N_CH must be at least 2");
   end

   for (genvar k = 0; k < N_CH; k++) begin : g_slot
      localparam int unsigned NIB = N_CH - 1 - k;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chars[8*k +: 8] <= BLANK_CH;
         else if (word_we)
            chars[8*k +: 8] <= nib2ascii(word[4*NIB +: 4]);
         else if (slot_we && (slot_idx == IDX_W'(k)))
            chars[8*k +: 8] <= slot_byte;
      end
   end

   AST_CHARS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_we || slot_we) |=> $stable(chars)); // R6

endmodule

// File: rtl/brdctl_i2c_port.sv
module brdctl_i2c_port #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] IN_RST  = 3,
   parameter logic [DATA_W-1:0] OUT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oe_we,
   input  logic              out_we,
   input  logic              sel_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sda_i,
   output logic [1:0]        oe_q,
   output logic [DATA_W-1:0] out_q,
   output logic              sel_q,
   output logic [DATA_W-1:0] in_word,
   output logic              scl_o,
   output logic              sda_o
);

   initial begin
      assert (DATA_W >= 2) else $error("brdctl_i2c_port: DATA_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 2'b00;
         out_q <= OUT_RST;
         sel_q <= 1'b1;
      end else begin
         if (oe_we)  oe_q  <= wdata[1:0];
         if (out_we) out_q <= wdata;
         if (sel_we) sel_q <= wdata[0];
      end
   end

   assign scl_o   = out_q[1];
   assign sda_o   = out_q[0];
   assign in_word = {IN_RST[DATA_W-1:1], sda_i};

   AST_LINE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |=> (scl_o == $past(wdata[1])) && (sda_o == $past(wdata[0]))); // R10

endmodule

// File: rtl/brdctl_regs.sv
module brdctl_regs
   import brdctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b1,
   localparam int unsigned N_CH      = DATA_W / 4,
   localparam int unsigned IDX_W     = $clog2(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sda_i,
   output logic              scl_o,
   output logic              sda_o,
   output logic [7:0]        led_bar,
   output logic [7:0]        brk_byte,
   output logic [7:0]        gp_out,
   output logic [N_CH*8-1:0] disp_chars,
   output logic              sys_rst_req
);

   initial begin
      assert (DATA_W == 32) else $error("brdctl_regs: DATA_W must be 32");
      assert (ADDR_W > OFF_W) else $error("brdctl_regs: ADDR_W must exceed offset width");
   end

   localparam off_t SLOT_LAST = OFS_SLOT0 + off_t'((N_CH - 1) * 8);

   off_t off;
   logic unused_addr_hi;
   assign off            = bus_addr[OFF_W-1:0];
   assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

   // ---------------- write decode ----------------
   logic wr_leds, wr_brk, wr_gpo, wr_swrst, wr_hex, wr_slot;
   logic wr_oe, wr_i2co, wr_sel;
   logic [IDX_W-1:0] slot_idx;
   off_t slot_rel;

   assign wr_leds  = bus_wr && (off == OFS_LEDS);
   assign wr_brk   = bus_wr && (off == OFS_BRK);
   assign wr_gpo   = bus_wr && (off == OFS_GPOUT);
   assign wr_swrst = bus_wr && (off == OFS_SWRST);
   assign wr_hex   = bus_wr && (off == OFS_HEXWORD);
   assign wr_oe    = bus_wr && (off == OFS_I2COE);
   assign wr_i2co  = bus_wr && (off == OFS_I2COUT);
   assign wr_sel   = bus_wr && (off == OFS_I2CSEL);
   assign slot_rel = off - OFS_SLOT0;
   assign slot_idx = slot_rel[IDX_W+2:3];
   assign wr_slot  = bus_wr && (off >= OFS_SLOT0) && (off <= SLOT_LAST)
                     && (off[2:0] == 3'b000);

   // ---------------- byte registers and reset request ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_bar     <= 8'h00;
         brk_byte    <= BRK_RST;
         gp_out      <= 8'h00;
         sys_rst_req <= 1'b0;
      end else begin
         if (wr_leds) led_bar  <= bus_wdata[7:0];
         if (wr_brk)  brk_byte <= bus_wdata[7:0];
         if (wr_gpo)  gp_out   <= bus_wdata[7:0];
         sys_rst_req <= wr_swrst && (bus_wdata == SWRST_KEY);
      end
   end

   // ---------------- display characters ----------------
   brdctl_charbank #(.N_CH(N_CH), .IDX_W(IDX_W)) u_charbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we   (wr_hex),
      .word      (bus_wdata),
      .slot_we   (wr_slot),
      .slot_idx  (slot_idx),
      .slot_byte (bus_wdata[7:0]),
      .chars     (disp_chars)
   );

   // ---------------- bit-banged I2C group ----------------
   logic [1:0]        i2c_oe;
   logic [DATA_W-1:0] i2c_out;
   logic              i2c_sel;
   logic [DATA_W-1:0] i2c_in;

   brdctl_i2c_port #(.DATA_W(DATA_W)) u_i2c (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_we   (wr_oe),
      .out_we  (wr_i2co),
      .sel_we  (wr_sel),
      .wdata   (bus_wdata),
      .sda_i   (sda_i),
      .oe_q    (i2c_oe),
      .out_q   (i2c_out),
      .sel_q   (i2c_sel),
      .in_word (i2c_in),
      .scl_o   (scl_o),
      .sda_o   (sda_o)
   );

   // ---------------- identification constant ----------------
   logic [DATA_W-1:0] status_val;
   if (BIG_ENDIAN) begin : g_be
      assign status_val = DATA_W'(32'h12);
   end else begin : g_le
      assign status_val = DATA_W'(32'h10);
   end

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (off)
         OFS_STATUS: rd_mux = status_val;
         OFS_LEDS:   rd_mux = DATA_W'(led_bar);
         OFS_BRK:    rd_mux = DATA_W'(brk_byte);
         OFS_GPOUT:  rd_mux = DATA_W'(gp_out);
         OFS_GPIN:   rd_mux = i2c_sel ? i2c_out : '0;
         OFS_I2CIN:  rd_mux = i2c_in;
         OFS_I2COE:  rd_mux = DATA_W'(i2c_oe);
         OFS_I2COUT: rd_mux = i2c_out;
         OFS_I2CSEL: rd_mux = DATA_W'(i2c_sel);
         default:    rd_mux = '0;
      endcase
   end
   assign bus_rdata = bus_rd ? rd_mux : '0;

   // ---------------- assertions ----------------
   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(bus_wr && (off == OFS_SWRST) && (bus_wdata == SWRST_KEY))); // R7

   AST_REQ_WRONG_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (off == OFS_SWRST) && (bus_wdata != SWRST_KEY)) |=> !sys_rst_req); // R7

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (off == OFS_LEDS)) |=> $stable(led_bar)); // R4

   AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (off == OFS_GPOUT)) |=> $stable(gp_out)); // R11

endmodule

// File: tb/brdctl_regs_bench.sv
module brdctl_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] addr = '0, wdata = '0;
   logic        sda_i = 1'b1;
   logic [31:0] rdata, rdata_le;
   logic        scl, sda, req;
   logic [7:0]  led, brk, gpo;
   logic [63:0] chars;
   logic        le_scl, le_sda, le_req;
   logic [7:0]  le_led, le_brk, le_gpo;
   logic [63:0] le_chars;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   brdctl_regs #(.BIG_ENDIAN(1'b1)) u_brdctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .sda_i(sda_i), .scl_o(scl),
      .sda_o(sda), .led_bar(led), .brk_byte(brk), .gp_out(gpo),
      .disp_chars(chars), .sys_rst_req(req)
   );

   brdctl_regs #(.BIG_ENDIAN(1'b0)) u_brdctl_regs_le (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata_le), .sda_i(sda_i), .scl_o(le_scl),
      .sda_o(le_sda), .led_bar(le_led), .brk_byte(le_brk), .gp_out(le_gpo),
      .disp_chars(le_chars), .sys_rst_req(le_req)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one write; returns on the falling edge after the capturing edge.
   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      #1 d = rdata;
      #1 rd = 1'b0; addr = '0;
   endtask

   function automatic logic [7:0] hexch(input logic [3:0] n);
      return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
   endfunction

   function automatic logic [63:0] hex_expect(input logic [31:0] v);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = hexch(v[31-4*k -: 4]);
      return r;
   endfunction

   task automatic t_reset_state();
      logic [31:0] d;
      chk("R1 led", led, 0);
      chk("R1 brk", brk, 8'h0A);
      chk("R1 gpo", gpo, 0);
      chk("R1 chars", chars, {8{8'h20}});
      chk("R1 scl/sda", {scl, sda}, 2'b11);
      chk("R1 req", req, 0);
      bus_read(32'hB08, d); chk("R1 i2c oe", d, 0);
      bus_read(32'hB10, d); chk("R1 i2c out", d, 3);
      bus_read(32'hB18, d); chk("R1 i2c sel", d, 1);
   endtask

   task automatic t_ident_regs();
      logic [31:0] d;
      @(negedge clk); rd = 1'b1; addr = 32'h208;
      #1 chk("R3 status BE", rdata, 32'h12);
      chk("R3 status LE", rdata_le, 32'h10);
      #1 rd = 1'b0; addr = '0;
      bus_write(32'h200, 32'hFFFF_FFFF);
      bus_write(32'h210, 32'hFFFF_FFFF);
      bus_read(32'h200, d); chk("R3 switch", d, 0);
      bus_read(32'h210, d); chk("R3 jumper", d, 0);
   endtask

   task automatic t_widths();
      logic [31:0] d;
      bus_write(32'h408, 32'h1234_56A5);
      chk("R4 led port", led, 8'hA5);
      bus_read(32'h408, d); chk("R4 led read", d, 32'hA5);
      bus_write(32'h508, 32'hFFFF_FF3C);
      chk("R4 brk port", brk, 8'h3C);
      bus_write(32'hA00, 32'h0000_0181);
      chk("R4 gpo port", gpo, 8'h81);
      bus_read(32'hA00, d); chk("R4 gpo read", d, 32'h81);
      bus_write(32'hB08, 32'hFF);
      bus_read(32'hB08, d); chk("R4 oe read", d, 3);
      bus_write(32'hB18, 32'h6);
      bus_read(32'hB18, d); chk("R4 sel read", d, 0);
   endtask

   task automatic t_gpin_i2c();
      logic [31:0] d;
      bus_read(32'hA08, d); chk("R8 gpin sel0", d, 0);
      bus_write(32'hB10, 32'hDEAD_BEE2);
      chk("R10 scl/sda", {scl, sda}, 2'b10);
      bus_read(32'hB10, d); chk("R10 out word", d, 32'hDEAD_BEE2);
      bus_write(32'hB18, 32'h1);
      bus_read(32'hA08, d); chk("R8 gpin sel1", d, 32'hDEAD_BEE2);
      bus_write(32'hB10, 32'h1);
      chk("R10 scl/sda second", {scl, sda}, 2'b01);
   endtask

   task automatic t_i2c_in();
      logic [31:0] d;
      sda_i = 1'b0;
      bus_read(32'hB00, d); chk("R9 sda low", d, 2);
      sda_i = 1'b1;
      bus_read(32'hB00, d); chk("R9 sda high", d, 3);
   endtask

   task automatic t_hexword();
      bus_write(32'h410, 32'h1A2B_C3D4);
      chk("R5 hex a", chars, hex_expect(32'h1A2B_C3D4));
      chk("R5 hex literal", chars, 64'h3444_3343_4232_4131);
      bus_write(32'h410, 32'hF09E_0000);
      chk("R5 hex b", chars, hex_expect(32'hF09E_0000));
   endtask

   task automatic t_slots();
      logic [63:0] exp;
      exp = chars;
      bus_write(32'h418 + 3*8, 32'h1234_5678);
      exp[3*8 +: 8] = 8'h78;
      chk("R6 slot3", chars, exp);
      bus_write(32'h450, 32'h7A);
      exp[7*8 +: 8] = 8'h7A;
      chk("R6 slot7", chars, exp);
      bus_write(32'h41C, 32'h55);
      chk("R11 misaligned slot", chars, exp);
   endtask

   task automatic t_swrst();
      bus_write(32'h500, 32'h43);
      chk("R7 wrong key", req, 0);
      bus_write(32'h500, 32'h142);
      chk("R7 upper bits", req, 0);
      bus_write(32'h500, 32'h42);
      chk("R7 pulse", req, 1);
      @(negedge clk);
      chk("R7 pulse width", req, 0);
   endtask

   task automatic t_unmapped_alias();
      logic [31:0] d;
      logic [7:0] led0;
      led0 = led;
      bus_write(32'h300, 32'hFF);
      chk("R11 unmapped write", {led, gpo, brk}, {led0, 8'h81, 8'h3C});
      bus_read(32'h300, d); chk("R11 unmapped read", d, 0);
      @(negedge clk); addr = 32'hB10; rd = 1'b0;
      #1 chk("R11 idle rdata", rdata, 0);
      addr = '0;
      bus_write(32'hFFF0_0408, 32'h5A);
      chk("R2 alias write", led, 8'h5A);
      bus_read(32'h7FF0_0408, d); chk("R2 alias read", d, 32'h5A);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset_state();
      t_ident_regs();
      t_widths();
      t_gpin_i2c();
      t_i2c_in();
      t_hexword();
      t_slots();
      t_swrst();
      t_unmapped_alias();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule